// File: doc/BRIEF.md
# Serial Flash Status Register Unit

This block holds the status byte of a serial flash device and serves it over an SPI slave port (mode 0, most significant bit first). A host lowers chip-select, shifts in the status-read opcode 0x05, and then receives the status byte on the serial output. The device keeps sending the byte, one copy after another, for as long as chip-select stays low. This lets the host poll the busy flag without sending the command again. Each repeated copy is a fresh snapshot, taken at the byte boundary.

The same unit owns the protection and write-control state. It holds the three block-protect bits and the protect bit in the top position. When the OTP-mode input is high, the top position reports a separate, one-way OTP lock flag instead. It also holds the volatile write-enable latch and derives the write-in-progress flag. That flag combines an internal write-status cycle, a program or erase it has started, and the busy input from an external program/erase engine. Program, erase and write-status requests are accepted only when the enable latch is set and nothing is in progress. An accepted program or erase is handed to the engine as a one-cycle start pulse.

The SPI side is one state machine with four states:
- ST_IDLE: chip-select is high. When chip-select goes low the machine moves to ST_CMD.
- ST_CMD: the opcode is shifted in on rising clock edges. On the eighth rising edge the machine moves to ST_STATUS if the opcode is 0x05, and to ST_IGNORE for any other opcode.
- ST_STATUS: the status byte is shifted out on falling clock edges, byte after byte.
- ST_IGNORE: the output stays low.

Chip-select going high returns the machine from any state to ST_IDLE.

Top module: `spi_status_reg`

## Requirements
- R1: After the eight opcode bits 0x05 are sampled on rising SCK edges while chip-select is low, the status byte appears on spi_miso_o MSB first. Each bit changes only after a falling SCK edge and is held until the next falling edge.
- R2: While chip-select stays low after the opcode, the status byte is sent again and again with no gap.
- R3: Status byte layout is bit 7 = protect bit (or OTP lock, see R8), bits 6:5 = 0, bits 4:2 = block-protect bits BP2..BP0, bit 1 = write-enable latch, bit 0 = write-in-progress.
- R4: Bit 0 is 1 whenever busy_i is high, an internal write-status cycle of WSR_CYCLES clocks is running, or an accepted program/erase has not yet completed. It is readable over SPI during that time.
- R5: A program, erase or write-status request made while the enable latch is 0 or bit 0 is 1 starts nothing. No start pulse is sent and the status bits are unchanged.
- R6: wren_set_i sets the enable latch and wren_clr_i clears it. The latch also clears when an accepted cycle completes: the write-status counter expires, or busy_i falls after a start.
- R7: After reset the block-protect bits read 111, the protect bit and the OTP lock read 0, and the enable latch reads 0.
- R8: With otp_mode_i high, bit 7 reports the OTP lock flag. An accepted write-status sets that flag from data bit 7 and never clears it, and leaves the protect bit untouched.
- R9: The status byte is snapshotted at each byte boundary. A change of bit 0 in the middle of a byte shows up only in the next byte.
- R10: After any opcode other than 0x05, spi_miso_o stays 0 until chip-select rises.
- R11: An accepted write-status request loads BP2..BP0 from wsr_data_i[4:2]. Outside OTP mode it also loads the protect bit from wsr_data_i[7]. Data bits 6:5 and 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; SPI lines are oversampled |
| rst_n | input | 1 | Active-low power-up reset |
| spi_sck_i | input | 1 | SPI serial clock (mode 0) |
| spi_cs_n_i | input | 1 | SPI chip-select, active low |
| spi_mosi_i | input | 1 | SPI serial data in |
| spi_miso_o | output | 1 | SPI serial data out |
| otp_mode_i | input | 1 | Selects OTP lock meaning for bit 7 |
| busy_i | input | 1 | Busy flag of the program/erase engine |
| wren_set_i | input | 1 | Pulse: set the write-enable latch |
| wren_clr_i | input | 1 | Pulse: clear the write-enable latch |
| prog_req_i | input | 1 | Pulse: program request |
| erase_req_i | input | 1 | Pulse: erase request |
| wsr_req_i | input | 1 | Pulse: write-status request |
| wsr_data_i | input | 8 | New status value for a write-status request |
| prog_start_o | output | 1 | One-cycle start for an accepted program |
| erase_start_o | output | 1 | One-cycle start for an accepted erase |
| bp_o | output | 3 | Block-protect bits BP2..BP0 |
| srp_o | output | 1 | Protect bit |
| otp_lock_o | output | 1 | OTP lock flag |

## Verification
The assertions check these rules on every cycle:
- A locked enable latch is never followed by a start pulse.
- High busy_i always shows in bit 0.
- The block-protect bits move only on an accepted write-status.
- The OTP lock never falls.
- The output bit holds between falling edges while in ST_STATUS, and is low in ST_IGNORE.

Only the bench scenarios can show the serial byte order, the continuous repetition, the byte-boundary snapshot, the reset defaults and the exact field positions. For these, the bench sweeps all 256 write-status values and all non-status opcodes over the SPI port.

// File: rtl/spi_sr_pkg.sv
package spi_sr_pkg;
    localparam int unsigned SR_BITS = 8;
    localparam logic [SR_BITS-1:0] OPC_STATUS_READ = 8'h05;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CMD,
        ST_STATUS,
        ST_IGNORE
    } shift_state_e;
endpackage

// File: rtl/sr_spi_sync.sv
module sr_spi_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic cs_n_i,
    input  logic mosi_i,
    output logic cs_n_o,
    output logic mosi_o,
    output logic sck_rise_o,
    output logic sck_fall_o
);
    localparam logic [2:0] RST_VAL = 3'b010;   // {sck, cs_n, mosi}

    logic [2:0] stg_q [STAGES];
    logic       sck_prev_q;

    genvar g;
    for (g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= RST_VAL;
                else        stg_q[g] <= {sck_i, cs_n_i, mosi_i};
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= RST_VAL;
                else        stg_q[g] <= stg_q[g-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_prev_q <= 1'b0;
        else        sck_prev_q <= stg_q[STAGES-1][2];
    end

    assign cs_n_o     = stg_q[STAGES-1][1];
    assign mosi_o     = stg_q[STAGES-1][0];
    assign sck_rise_o =  stg_q[STAGES-1][2] & ~sck_prev_q;
    assign sck_fall_o = ~stg_q[STAGES-1][2] &  sck_prev_q;
endmodule

// File: rtl/sr_bits_core.sv
module sr_bits_core #(
    parameter int unsigned WSR_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       otp_mode_i,
    input  logic       busy_i,
    input  logic       wren_set_i,
    input  logic       wren_clr_i,
    input  logic       prog_req_i,
    input  logic       erase_req_i,
    input  logic       wsr_req_i,
    input  logic [7:0] wsr_data_i,
    output logic       prog_start_o,
    output logic       erase_start_o,
    output logic [2:0] bp_o,
    output logic       srp_o,
    output logic       otp_lock_o,
    output logic [7:0] status_o
);
    localparam int unsigned CW = $clog2(WSR_CYCLES + 1);

    logic [2:0]    bp_q;
    logic          srp_q, otp_lock_q, wel_q;
    logic          pe_active_q, busy_prev_q;
    logic [CW-1:0] wsr_cnt_q;
    logic          wip, acc_ok, wsr_acc, prog_acc, erase_acc;
    logic          wsr_done, pe_done;
    logic          unused_data;

    assign unused_data = ^{wsr_data_i[6:5], wsr_data_i[1:0]};

    assign wip       = (wsr_cnt_q != '0) | pe_active_q | busy_i;
    assign acc_ok    = wel_q & ~wip;
    assign wsr_acc   = wsr_req_i & acc_ok;
    assign prog_acc  = prog_req_i & acc_ok & ~wsr_req_i;
    assign erase_acc = erase_req_i & acc_ok & ~wsr_req_i & ~prog_req_i;
    assign wsr_done  = (wsr_cnt_q == CW'(1));
    assign pe_done   = pe_active_q & busy_prev_q & ~busy_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bp_q          <= 3'b111;
            srp_q         <= 1'b0;
            otp_lock_q    <= 1'b0;
            wel_q         <= 1'b0;
            pe_active_q   <= 1'b0;
            busy_prev_q   <= 1'b0;
            wsr_cnt_q     <= '0;
            prog_start_o  <= 1'b0;
            erase_start_o <= 1'b0;
        end else begin
            busy_prev_q   <= busy_i;
            prog_start_o  <= prog_acc;
            erase_start_o <= erase_acc;
            if (wsr_done | pe_done | wren_clr_i) wel_q <= 1'b0;
            else if (wren_set_i)                 wel_q <= 1'b1;
            if (prog_acc | erase_acc)  pe_active_q <= 1'b1;
            else if (pe_done)          pe_active_q <= 1'b0;
            if (wsr_acc)               wsr_cnt_q <= CW'(WSR_CYCLES);
            else if (wsr_cnt_q != '0)  wsr_cnt_q <= wsr_cnt_q - CW'(1);
            if (wsr_acc) begin
                bp_q <= wsr_data_i[4:2];
                if (otp_mode_i) otp_lock_q <= otp_lock_q | wsr_data_i[7];
                else            srp_q      <= wsr_data_i[7];
            end
        end
    end

    assign status_o   = {(otp_mode_i ? otp_lock_q : srp_q), 2'b00, bp_q, wel_q, wip};
    assign bp_o       = bp_q;
    assign srp_o      = srp_q;
    assign otp_lock_o = otp_lock_q;

    AST_LOCKED_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        !wel_q |=> !(prog_start_o || erase_start_o));                    // R5
    AST_WIP_ON_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |-> status_o[0]);                                         // R4
    AST_BP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wsr_acc |=> $stable(bp_q));                                     // R11
    AST_OTP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        otp_lock_q |=> otp_lock_q);                                      // R8
endmodule

// File: rtl/sr_shift_fsm.sv
module sr_shift_fsm
    import spi_sr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n_i,
    input  logic               mosi_i,
    input  logic               sck_rise_i,
    input  logic               sck_fall_i,
    input  logic [SR_BITS-1:0] status_i,
    output logic               miso_o
);
    shift_state_e       state_q, state_d;
    logic [2:0]         bitcnt_q;
    logic [SR_BITS-2:0] cmd_q;
    logic [SR_BITS-2:0] out_q;

    always_comb begin
        state_d = state_q;
        if (cs_n_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_CMD;
                ST_CMD:    if (sck_rise_i && bitcnt_q == 3'd7)
                               state_d = ({cmd_q, mosi_i} == OPC_STATUS_READ) ? ST_STATUS : ST_IGNORE;
                ST_STATUS: state_d = ST_STATUS;
                ST_IGNORE: state_d = ST_IGNORE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt_q <= 3'd0;
            cmd_q    <= '0;
            out_q    <= '0;
            miso_o   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    bitcnt_q <= 3'd0;
                    miso_o   <= 1'b0;
                end
                ST_CMD: begin
                    miso_o <= 1'b0;
                    if (sck_rise_i) begin
                        cmd_q    <= {cmd_q[SR_BITS-3:0], mosi_i};
                        bitcnt_q <= bitcnt_q + 3'd1;
                    end
                end
                ST_STATUS: begin
                    if (sck_fall_i) begin
                        if (bitcnt_q == 3'd0) begin
                            miso_o <= status_i[SR_BITS-1];
                            out_q  <= status_i[SR_BITS-2:0];
                        end else begin
                            miso_o <= out_q[SR_BITS-2];
                            out_q  <= {out_q[SR_BITS-3:0], 1'b0};
                        end
                        bitcnt_q <= bitcnt_q + 3'd1;
                    end
                end
                ST_IGNORE: miso_o <= 1'b0;
            endcase
        end
    end

    AST_MISO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STATUS && !sck_fall_i) |=> $stable(miso_o));      // R1
    AST_QUIET_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IGNORE) |=> !miso_o);                             // R10
endmodule

// File: rtl/spi_status_reg.sv
module spi_status_reg
    import spi_sr_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned WSR_CYCLES  = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_sck_i,
    input  logic       spi_cs_n_i,
    input  logic       spi_mosi_i,
    output logic       spi_miso_o,
    input  logic       otp_mode_i,
    input  logic       busy_i,
    input  logic       wren_set_i,
    input  logic       wren_clr_i,
    input  logic       prog_req_i,
    input  logic       erase_req_i,
    input  logic       wsr_req_i,
    input  logic [7:0] wsr_data_i,
    output logic       prog_start_o,
    output logic       erase_start_o,
    output logic [2:0] bp_o,
    output logic       srp_o,
    output logic       otp_lock_o
);
    logic               cs_n_s, mosi_s, sck_rise, sck_fall;
    logic [SR_BITS-1:0] status;

    sr_spi_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n),
        .sck_i(spi_sck_i), .cs_n_i(spi_cs_n_i), .mosi_i(spi_mosi_i),
        .cs_n_o(cs_n_s), .mosi_o(mosi_s),
        .sck_rise_o(sck_rise), .sck_fall_o(sck_fall)
    );

    sr_bits_core #(.WSR_CYCLES(WSR_CYCLES)) core_i (
        .clk(clk), .rst_n(rst_n),
        .otp_mode_i(otp_mode_i), .busy_i(busy_i),
        .wren_set_i(wren_set_i), .wren_clr_i(wren_clr_i),
        .prog_req_i(prog_req_i), .erase_req_i(erase_req_i),
        .wsr_req_i(wsr_req_i), .wsr_data_i(wsr_data_i),
        .prog_start_o(prog_start_o), .erase_start_o(erase_start_o),
        .bp_o(bp_o), .srp_o(srp_o), .otp_lock_o(otp_lock_o),
        .status_o(status)
    );

    sr_shift_fsm fsm_i (
        .clk(clk), .rst_n(rst_n),
        .cs_n_i(cs_n_s), .mosi_i(mosi_s),
        .sck_rise_i(sck_rise), .sck_fall_i(sck_fall),
        .status_i(status), .miso_o(spi_miso_o)
    );
endmodule

// File: tb/spi_status_reg_tb_top.sv
`timescale 1ns/1ps
module spi_status_reg_tb_top;
    localparam int H    = 5;     // SCK half period in clk cycles
    localparam int WSRC = 150;   // write-status cycle length
    localparam int ENG  = 600;   // engine busy length

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso;
    logic otp_mode = 1'b0, force_busy = 1'b0, busy;
    logic wren_set = 1'b0, wren_clr = 1'b0;
    logic prog_req = 1'b0, erase_req = 1'b0, wsr_req = 1'b0;
    logic [7:0] wsr_data = 8'h00;
    logic prog_start, erase_start, srp, otp_lock;
    logic [2:0] bp;

    int checks = 0, errors = 0;
    int prog_starts = 0, erase_starts = 0;
    int eng_cnt = 0;
    logic done = 1'b0;
    logic m_srp = 1'b0, m_otp = 1'b0;
    logic [2:0] m_bp = 3'b111;

    always #5 clk = ~clk;

    spi_status_reg #(.SYNC_STAGES(2), .WSR_CYCLES(WSRC)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .spi_sck_i(sck), .spi_cs_n_i(cs_n), .spi_mosi_i(mosi), .spi_miso_o(miso),
        .otp_mode_i(otp_mode), .busy_i(busy),
        .wren_set_i(wren_set), .wren_clr_i(wren_clr),
        .prog_req_i(prog_req), .erase_req_i(erase_req),
        .wsr_req_i(wsr_req), .wsr_data_i(wsr_data),
        .prog_start_o(prog_start), .erase_start_o(erase_start),
        .bp_o(bp), .srp_o(srp), .otp_lock_o(otp_lock)
    );

    assign busy = (eng_cnt != 0) | force_busy;

    always @(posedge clk) begin
        if (!rst_n) eng_cnt <= 0;
        else if (prog_start || erase_start) eng_cnt <= ENG;
        else if (eng_cnt != 0) eng_cnt <= eng_cnt - 1;
        if (prog_start)  prog_starts <= prog_starts + 1;
        if (erase_start) erase_starts <= erase_starts + 1;
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_stat(input logic wel, input logic wip);
        return {(otp_mode ? m_otp : m_srp), 2'b00, m_bp, wel, wip};
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_bit(input logic mo, output logic mi);
        mosi = mo;
        wait_clk(H);
        mi = miso;
        sck = 1'b1;
        wait_clk(H);
        sck = 1'b0;
    endtask

    task automatic spi_begin(input logic [7:0] op);
        logic d;
        cs_n = 1'b0;
        wait_clk(H);
        for (int i = 7; i >= 0; i--) spi_bit(op[i], d);
    endtask

    task automatic spi_byte(output logic [7:0] b);
        for (int i = 7; i >= 0; i--) spi_bit(1'b0, b[i]);
    endtask

    task automatic spi_end();
        wait_clk(H);
        cs_n = 1'b1;
        wait_clk(2 * H + 4);
    endtask

    task automatic pulse(ref logic s);
        s = 1'b1;
        wait_clk(1);
        s = 1'b0;
    endtask

    task automatic write_status(input logic [7:0] d);
        wsr_data = d;
        pulse(wsr_req);
    endtask

    initial begin
        logic [7:0] b1, b2;
        int ps, es;
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);

        // R7: power-up defaults
        check("R7 bp", {13'd0, bp}, 16'h0007);
        check("R7 srp/otp", {14'd0, srp, otp_lock}, 16'h0000);
        // R1 R2 R3 R7: status read, repeated
        spi_begin(8'h05); spi_byte(b1); spi_byte(b2); spi_end();
        check("R1 R3 R7 first byte", {8'd0, b1}, 16'h001C);
        check("R2 repeat byte", {8'd0, b2}, 16'h001C);

        // R5: requests with latch clear
        ps = prog_starts; es = erase_starts;
        pulse(prog_req); pulse(erase_req); write_status(8'h00);
        wait_clk(5);
        check("R5 no start", 16'(prog_starts + erase_starts), 16'(ps + es));
        check("R5 bp unchanged", {13'd0, bp}, 16'h0007);

        // R6: latch set and clear
        pulse(wren_set);
        spi_begin(8'h05); spi_byte(b1); spi_end();
        check("R6 set", {8'd0, b1}, {8'd0, exp_stat(1'b1, 1'b0)});
        pulse(wren_clr);
        spi_begin(8'h05); spi_byte(b1); spi_end();
        check("R6 clear", {8'd0, b1}, {8'd0, exp_stat(1'b0, 1'b0)});

        // R11 R3 R4 R6 R2: exhaustive write-status sweep
        for (int v = 0; v < 256; v++) begin
            pulse(wren_set);
            write_status(8'(v));
            m_bp = v[4:2]; m_srp = v[7];
            spi_begin(8'h05); spi_byte(b1); spi_byte(b2); spi_end();
            check("R11 R4 during cycle", {8'd0, b1}, {8'd0, exp_stat(1'b1, 1'b1)});
            check("R6 R2 after cycle", {8'd0, b2}, {8'd0, exp_stat(1'b0, 1'b0)});
            check("R11 bp port", {12'd0, bp, srp}, {12'd0, m_bp, m_srp});
        end

        // R4 R5 R6: program via engine
        ps = prog_starts; es = erase_starts;
        pulse(wren_set); pulse(prog_req);
        wait_clk(3);
        check("R4 prog start", 16'(prog_starts), 16'(ps + 1));
        pulse(erase_req);
        wait_clk(3);
        check("R5 erase while busy", 16'(erase_starts), 16'(es));
        spi_begin(8'h05); spi_byte(b1); spi_byte(b2); spi_end();
        check("R4 busy byte1", {8'd0, b1}, {8'd0, exp_stat(1'b1, 1'b1)});
        check("R4 busy byte2", {8'd0, b2}, {8'd0, exp_stat(1'b1, 1'b1)});
        wait_clk(ENG + 10);
        spi_begin(8'h05); spi_byte(b1); spi_end();
        check("R6 clear on done", {8'd0, b1}, {8'd0, exp_stat(1'b0, 1'b0)});
        pulse(wren_set); pulse(erase_req);
        wait_clk(3);
        check("R4 erase start", 16'(erase_starts), 16'(es + 1));
        wait_clk(ENG + 10);

        // R9: busy change mid-byte seen in next byte
        spi_begin(8'h05);
        for (int i = 7; i >= 5; i--) spi_bit(1'b0, b1[i]);
        force_busy = 1'b1;
        for (int i = 4; i >= 0; i--) spi_bit(1'b0, b1[i]);
        spi_byte(b2); spi_end();
        force_busy = 1'b0;
        check("R9 byte1 old snapshot", {8'd0, b1}, {8'd0, exp_stat(1'b0, 1'b0)});
        check("R9 byte2 new snapshot", {8'd0, b2}, {8'd0, exp_stat(1'b0, 1'b1)});
        wait_clk(4);

        // R8: OTP lock on bit 7 (srp is 1 from the sweep)
        otp_mode = 1'b1;
        spi_begin(8'h05); spi_byte(b1); spi_end();
        check("R8 lock shown", {8'd0, b1}, {8'd0, exp_stat(1'b0, 1'b0)});
        pulse(wren_set); write_status(8'h80); m_otp = 1'b1; m_bp = 3'b000;
        wait_clk(WSRC + 5);
        check("R8 lock set srp kept", {14'd0, otp_lock, srp}, 16'h0003);
        pulse(wren_set); write_status(8'h00);
        wait_clk(WSRC + 5);
        spi_begin(8'h05); spi_byte(b1); spi_end();
        check("R8 lock sticky", {8'd0, b1}, {8'd0, exp_stat(1'b0, 1'b0)});
        otp_mode = 1'b0;
        pulse(wren_set); write_status(8'h00); m_srp = 1'b0;
        wait_clk(WSRC + 5);
        spi_begin(8'h05); spi_byte(b1); spi_end();
        check("R8 normal bit7", {8'd0, b1}, {8'd0, exp_stat(1'b0, 1'b0)});
        check("R8 lock kept", {15'd0, otp_lock}, 16'h0001);

        // R10: every other opcode keeps output low
        for (int op = 0; op < 256; op++) begin
            if (op == 5) continue;
            spi_begin(8'(op)); spi_byte(b1); spi_byte(b2); spi_end();
            check("R10 quiet", {b1, b2}, 16'h0000);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule